// File: doc/BRIEF.md
# Segmented Sector Write Pointer

This block produces the byte addresses at which incoming sectors are stored in a buffer RAM that is carved into fixed-size segments. Each segment spans 2560 bytes, which is not a power of two. A byte address is therefore formed as segment number times the segment size plus an in-segment offset. A sector-sync pulse marks each sector boundary, and a byte strobe marks each data byte. The block drives the address together with a write enable for the memory controller next to it.

The pointer state is held in two register sets. The current set holds the segment being filled and the number of sectors left in the current group. The next set holds the values that replace the current set when that group runs out. On that swap a sticky interrupt flag is raised, so that a controller can refill the next set before the new group is also used up. If the next set is left unchanged, the transfer keeps cycling over the same buffer area. Control bits choose whether the segment pointer advances at each sector and whether data is actually written. A controller can therefore either overwrite one segment repeatedly, or step through segments without storing anything. A snapshot register keeps the segment number of the sector that has just finished.

Top module: `segbuf_wrptr`

## Requirements
- R1: The output address equals current segment × SEG_BYTES + offset. The offset is 0 after each sector sync and rises by one for each accepted byte strobe.
- R2: At each sector end, the current segment rises by one (wrapping modulo 2^SEG_W) when the advance-enable bit (control bit 0) is 1. It keeps its value when that bit is 0.
- R3: At each sector end that does not reload, the sector count falls by one, whatever the advance-enable bit is.
- R4: At a sector end where the count is 1 or 0, the current segment and count are loaded from the next-segment and next-count registers.
- R5: A reload sets the interrupt flag when the interrupt-enable bit (control bit 2) is 1. The flag stays set until a write to selector 5. If a reload and a clear happen in the same cycle, the reload wins.
- R6: At each sector end the previous-segment output takes the value the current segment had just before that sector end.
- R7: While the write-disable bit (control bit 1) is 1, the write enable stays low, but the offset, segment and count still advance.
- R8: Once the offset reaches SEG_BYTES, further byte strobes are not written and the offset holds until the next sync.
- R9: A sector end is any sync after the first sync since reset. The first sync only opens a sector. Byte strobes before that first sync, and a byte strobe in the same cycle as a sync, are not written.
- R10: When the next registers are not rewritten, successive reloads return to the same segment and count, so the buffer area is reused in a loop.
- R11: After reset, all pointers, counts and control bits are 0, and the write enable and interrupt are low.
- R12: Register writes select by `cfg_sel_i`: 0 current segment, 1 current count, 2 next segment, 3 next count, 4 control {irq_en, wr_dis, inc_en} in bits 2..0, 5 interrupt clear. A sector end overrides a same-cycle write to the current segment or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Sector-sync pulse |
| byte_vld_i | input | 1 | Incoming data byte strobe |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register selector |
| cfg_data_i | input | CFG_W (16) | Register write data |
| wr_addr_o | output | SEG_W+OFS_W (28) | Physical byte address |
| wr_en_o | output | 1 | Buffer RAM write enable |
| reload_irq_o | output | 1 | Sticky reload interrupt |
| prev_seg_o | output | SEG_W (16) | Segment of the sector just finished |
| cur_seg_o | output | SEG_W (16) | Current segment pointer |
| cur_cnt_o | output | CNT_W (16) | Sectors left in the current group |

## Verification
The bench builds the block with an 8-bit segment number, a 4-bit sector count, a 12-bit offset and the full 2560-byte segment size. The narrow segment field lets a short run step the pointer across its wrap from 255 to 0. The small count lets programmed groups and reload loops finish within a few sectors. Keeping the real segment size, rather than a power of two, exercises the multiplying address path. A 2600-byte sector then drives the offset past its end limit.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;

    typedef enum logic [2:0] {
        SEL_CUR_SEG = 3'd0,
        SEL_CUR_CNT = 3'd1,
        SEL_NXT_SEG = 3'd2,
        SEL_NXT_CNT = 3'd3,
        SEL_CTRL    = 3'd4,
        SEL_IRQ_CLR = 3'd5
    } cfg_sel_e;

    // bit 0 advance enable, bit 1 write disable, bit 2 interrupt enable
    typedef struct packed {
        logic irq_en;
        logic wr_dis;
        logic inc_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // sector boundary events produced by the pointer unit
    typedef struct packed {
        logic close;   // a sector ended
        logic reload;  // group exhausted, swap in next set
    } sect_evt_t;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/segbuf_regs.sv
module segbuf_regs
    import segbuf_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int CNT_W = 16,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  cfg_sel_e         cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             reload,
    output logic [SEG_W-1:0] nxt_seg,
    output logic [CNT_W-1:0] nxt_cnt,
    output ctrl_t            ctrl,
    output logic             irq
);

    logic irq_clr;
    assign irq_clr = cfg_we && (cfg_sel == SEL_IRQ_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_seg <= '0;
            nxt_cnt <= '0;
            ctrl    <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_NXT_SEG: nxt_seg <= cfg_data[SEG_W-1:0];
                SEL_NXT_CNT: nxt_cnt <= cfg_data[CNT_W-1:0];
                SEL_CTRL:    ctrl    <= ctrl_t'(cfg_data[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    // sticky flag: a reload beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (reload && ctrl.irq_en)
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end

    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_clr |=> irq);

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(reload));

endmodule

// File: rtl/segbuf_ptr.sv
module segbuf_ptr
    import segbuf_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int CNT_W = 16,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync,
    input  logic             cfg_we,
    input  cfg_sel_e         cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [SEG_W-1:0] nxt_seg,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic             inc_en,
    output logic [SEG_W-1:0] cur_seg,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [SEG_W-1:0] prev_seg,
    output logic             in_sector,
    output sect_evt_t        evt
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [SEG_W-1:0] seg_step;
    assign seg_step = {{(SEG_W-1){1'b0}}, inc_en};

    always_comb begin
        evt.close  = sync && in_sector;
        evt.reload = evt.close && (cur_cnt <= CNT_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_seg   <= '0;
            cur_cnt   <= '0;
            prev_seg  <= '0;
            in_sector <= 1'b0;
        end else begin
            if (sync)
                in_sector <= 1'b1;
            if (evt.close) begin
                prev_seg <= cur_seg;
                if (evt.reload) begin
                    cur_seg <= nxt_seg;
                    cur_cnt <= nxt_cnt;
                end else begin
                    cur_seg <= cur_seg + seg_step;
                    cur_cnt <= cur_cnt - CNT_ONE;
                end
            end else if (cfg_we) begin
                case (cfg_sel)
                    SEL_CUR_SEG: cur_seg <= cfg_data[SEG_W-1:0];
                    SEL_CUR_CNT: cur_cnt <= cfg_data[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assert_cnt_dec_R3: assert property (@(posedge clk) disable iff (rst)
        evt.close && !evt.reload |=> cur_cnt == $past(cur_cnt) - CNT_ONE);

    assert_seg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        evt.close && !evt.reload && !inc_en |=> cur_seg == $past(cur_seg));

    assert_reload_load_R4: assert property (@(posedge clk) disable iff (rst)
        evt.reload |=> cur_seg == $past(nxt_seg) && cur_cnt == $past(nxt_cnt));

    assert_prev_capture_R6: assert property (@(posedge clk) disable iff (rst)
        evt.close |=> prev_seg == $past(cur_seg));

endmodule

// File: rtl/segbuf_ofs.sv
module segbuf_ofs
    import segbuf_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 12,
    parameter int SEG_BYTES = 2560,
    localparam int ADDR_W   = SEG_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync,
    input  logic              byte_vld,
    input  logic              in_sector,
    input  logic              wr_dis,
    input  logic [SEG_W-1:0]  cur_seg,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_en
);

    localparam logic [OFS_W-1:0] OFS_END = OFS_W'(SEG_BYTES);
    localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);

    logic [OFS_W-1:0]  offset;
    logic [ADDR_W-1:0] seg_base;
    logic              accept;

    assign accept = byte_vld && !sync && in_sector && (offset < OFS_END);
    assign wr_en  = accept && !wr_dis;

    always_ff @(posedge clk) begin
        if (rst)
            offset <= '0;
        else if (sync)
            offset <= '0;
        else if (accept)
            offset <= offset + OFS_ONE;
    end

    // segment base: shift when the stride is a power of two, else multiply
    generate
        if (is_pow2(SEG_BYTES)) begin : g_shift_base
            assign seg_base = ADDR_W'(cur_seg) << $clog2(SEG_BYTES);
        end else begin : g_mult_base
            assign seg_base = ADDR_W'(cur_seg) * ADDR_W'(SEG_BYTES);
        end
    endgenerate

    assign wr_addr = seg_base + ADDR_W'(offset);

    assert_no_write_past_end_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> offset < OFS_END);

    assert_offset_restart_R1: assert property (@(posedge clk) disable iff (rst)
        sync |=> offset == '0);

    assert_offset_step_R1: assert property (@(posedge clk) disable iff (rst)
        accept |=> offset == $past(offset) + OFS_ONE);

endmodule

// File: rtl/segbuf_wrptr.sv
module segbuf_wrptr
    import segbuf_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 12,
    parameter int CNT_W     = 16,
    parameter int CFG_W     = 16,
    parameter int SEG_BYTES = 2560,
    localparam int ADDR_W   = SEG_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    input  logic              byte_vld_i,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [CFG_W-1:0]  cfg_data_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_en_o,
    output logic              reload_irq_o,
    output logic [SEG_W-1:0]  prev_seg_o,
    output logic [SEG_W-1:0]  cur_seg_o,
    output logic [CNT_W-1:0]  cur_cnt_o
);

    cfg_sel_e         sel;
    logic [SEG_W-1:0] nxt_seg;
    logic [CNT_W-1:0] nxt_cnt;
    ctrl_t            ctrl;
    logic             in_sector;
    sect_evt_t        evt;

    assign sel = cfg_sel_e'(cfg_sel_i);

    segbuf_regs #(.SEG_W(SEG_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we_i),
        .cfg_sel  (sel),
        .cfg_data (cfg_data_i),
        .reload   (evt.reload),
        .nxt_seg  (nxt_seg),
        .nxt_cnt  (nxt_cnt),
        .ctrl     (ctrl),
        .irq      (reload_irq_o)
    );

    segbuf_ptr #(.SEG_W(SEG_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .sync      (sync_i),
        .cfg_we    (cfg_we_i),
        .cfg_sel   (sel),
        .cfg_data  (cfg_data_i),
        .nxt_seg   (nxt_seg),
        .nxt_cnt   (nxt_cnt),
        .inc_en    (ctrl.inc_en),
        .cur_seg   (cur_seg_o),
        .cur_cnt   (cur_cnt_o),
        .prev_seg  (prev_seg_o),
        .in_sector (in_sector),
        .evt       (evt)
    );

    segbuf_ofs #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_BYTES(SEG_BYTES)) u_ofs (
        .clk       (clk),
        .rst       (rst),
        .sync      (sync_i),
        .byte_vld  (byte_vld_i),
        .in_sector (in_sector),
        .wr_dis    (ctrl.wr_dis),
        .cur_seg   (cur_seg_o),
        .wr_addr   (wr_addr_o),
        .wr_en     (wr_en_o)
    );

    assert_wrdis_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.wr_dis |-> !wr_en_o);

    assert_no_write_unopened_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_sector || sync_i) |-> !wr_en_o);

endmodule

// File: tb/segbuf_wrptr_bench.sv
module segbuf_wrptr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SEG_W      = 8;
    localparam int OFS_W      = 12;
    localparam int CNT_W      = 4;
    localparam int CFG_W      = 16;
    localparam int SEG_BYTES  = 2560;
    localparam int ADDR_W     = SEG_W + OFS_W;
    localparam int SEGN       = 1 << SEG_W;
    localparam int CNTN       = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sync_i = 1'b0;
    logic              byte_vld_i = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [2:0]        cfg_sel_i = '0;
    logic [CFG_W-1:0]  cfg_data_i = '0;
    logic [ADDR_W-1:0] wr_addr_o;
    logic              wr_en_o;
    logic              reload_irq_o;
    logic [SEG_W-1:0]  prev_seg_o;
    logic [SEG_W-1:0]  cur_seg_o;
    logic [CNT_W-1:0]  cur_cnt_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    segbuf_wrptr #(
        .SEG_W(SEG_W), .OFS_W(OFS_W), .CNT_W(CNT_W),
        .CFG_W(CFG_W), .SEG_BYTES(SEG_BYTES)
    ) u_segbuf_wrptr (
        .clk(clk), .rst(rst), .sync_i(sync_i), .byte_vld_i(byte_vld_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
        .wr_addr_o(wr_addr_o), .wr_en_o(wr_en_o), .reload_irq_o(reload_irq_o),
        .prev_seg_o(prev_seg_o), .cur_seg_o(cur_seg_o), .cur_cnt_o(cur_cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int m_seg, m_cnt, m_prev, m_ofs, m_nseg, m_ncnt;
    bit m_insec, m_inc, m_wdis, m_ien, m_irq;

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            m_seg = 0; m_cnt = 0; m_prev = 0; m_ofs = 0; m_nseg = 0; m_ncnt = 0;
            m_insec = 0; m_inc = 0; m_wdis = 0; m_ien = 0; m_irq = 0;
        end else if (!done) begin
            bit ok, cl, rl;
            int n_seg, n_cnt, n_prev, n_ofs;
            bit n_irq;
            ok = byte_vld_i && !sync_i && m_insec && (m_ofs < SEG_BYTES);
            cmp("R1 wr_addr", int'(wr_addr_o), m_seg * SEG_BYTES + m_ofs);
            cmp("R7/R8/R9 wr_en", int'(wr_en_o), int'(ok && !m_wdis));
            cmp("R5 irq", int'(reload_irq_o), int'(m_irq));
            cmp("R6 prev_seg", int'(prev_seg_o), m_prev);
            cmp("R2 cur_seg", int'(cur_seg_o), m_seg);
            cmp("R3 cur_cnt", int'(cur_cnt_o), m_cnt);
            // advance the model by what the coming edge does
            cl = sync_i && m_insec;
            rl = cl && (m_cnt <= 1);
            n_seg = m_seg; n_cnt = m_cnt; n_prev = m_prev; n_ofs = m_ofs; n_irq = m_irq;
            if (sync_i) n_ofs = 0;
            else if (ok) n_ofs = m_ofs + 1;
            if (cl) begin
                n_prev = m_seg;
                if (rl) begin n_seg = m_nseg; n_cnt = m_ncnt; end
                else begin n_seg = (m_seg + int'(m_inc)) % SEGN; n_cnt = m_cnt - 1; end
            end else if (cfg_we_i) begin
                if (cfg_sel_i == 3'd0) n_seg = int'(cfg_data_i) % SEGN;
                if (cfg_sel_i == 3'd1) n_cnt = int'(cfg_data_i) % CNTN;
            end
            if (rl && m_ien) n_irq = 1;
            else if (cfg_we_i && cfg_sel_i == 3'd5) n_irq = 0;
            if (cfg_we_i) begin
                case (cfg_sel_i)
                    3'd2: m_nseg = int'(cfg_data_i) % SEGN;
                    3'd3: m_ncnt = int'(cfg_data_i) % CNTN;
                    3'd4: begin m_inc = cfg_data_i[0]; m_wdis = cfg_data_i[1]; m_ien = cfg_data_i[2]; end
                    default: ;
                endcase
            end
            if (sync_i) m_insec = 1;
            m_seg = n_seg; m_cnt = n_cnt; m_prev = n_prev; m_ofs = n_ofs; m_irq = n_irq;
        end
    end

    task automatic step_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            sync_i = 0; byte_vld_i = 0; cfg_we_i = 0;
        end
    endtask

    task automatic reg_wr(input logic [2:0] sel, input int data);
        @(posedge clk); #1;
        sync_i = 0; byte_vld_i = 0; cfg_we_i = 1;
        cfg_sel_i = sel; cfg_data_i = CFG_W'(data);
        @(posedge clk); #1;
        cfg_we_i = 0;
    endtask

    // one sync (with a coincident strobe) followed by nbytes strobes
    task automatic sector(input int nbytes, input bit gappy);
        @(posedge clk); #1;
        sync_i = 1; byte_vld_i = 1; cfg_we_i = 0;
        for (int i = 0; i < nbytes; i++) begin
            @(posedge clk); #1;
            sync_i = 0; byte_vld_i = 1;
            if (gappy) begin
                @(posedge clk); #1;
                byte_vld_i = 0;
            end
        end
    endtask

    task automatic look(input string tag, input int act, input int exp);
        @(negedge clk);
        cmp(tag, act, exp);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        look("R11 reset wr_en", int'(wr_en_o), 0);
        cmp("R11 reset irq", int'(reload_irq_o), 0);
        cmp("R11 reset cur_seg", int'(cur_seg_o), 0);
        // R9: strobes before any sync are dropped
        @(posedge clk); #1 byte_vld_i = 1;
        look("R9 strobe before first sync", int'(wr_en_o), 0);
        step_idle(2);
        // R12 register programming
        reg_wr(3'd2, 200);
        reg_wr(3'd3, 2);
        reg_wr(3'd0, 10);
        reg_wr(3'd1, 3);
        reg_wr(3'd4, 3'b101);
        // R4/R10: 10,11,12 then 200,201,200 ...
        for (int k = 0; k < 6; k++) sector(5, k[0]);
        look("R10 loop segment", int'(cur_seg_o), 200);
        cmp("R10 loop count", int'(cur_cnt_o), 2);
        cmp("R6 prev after loop", int'(prev_seg_o), 201);
        cmp("R5 irq raised", int'(reload_irq_o), 1);
        reg_wr(3'd5, 0);
        look("R5 irq cleared", int'(reload_irq_o), 0);
        // R2/R3: advance disabled
        reg_wr(3'd4, 3'b100);
        sector(4, 0);
        look("R2 hold segment", int'(cur_seg_o), 200);
        cmp("R3 count decrements", int'(cur_cnt_o), 1);
        sector(4, 0);
        // R7: write disabled, pointer still moves
        reg_wr(3'd4, 3'b011);
        reg_wr(3'd3, 15);
        sector(6, 0);
        look("R7 wr_en low", int'(wr_en_o), 0);
        cmp("R7 segment advanced", int'(cur_seg_o), 201);
        // R8: overlong sector
        reg_wr(3'd4, 3'b001);
        sector(2600, 0);
        look("R8 address clamps", int'(wr_addr_o), 200 * SEG_BYTES + SEG_BYTES);
        cmp("R8 wr_en past end", int'(wr_en_o), 0);
        // R2 wrap
        reg_wr(3'd0, 254);
        sector(2, 1);
        sector(2, 1);
        look("R2 wrap to zero", int'(cur_seg_o), 0);
        cmp("R6 prev at wrap", int'(prev_seg_o), 255);
        // R12: sector end beats same-cycle write to current segment
        @(posedge clk); #1;
        sync_i = 1; byte_vld_i = 0; cfg_we_i = 1; cfg_sel_i = 3'd0; cfg_data_i = 16'd77;
        @(posedge clk); #1;
        sync_i = 0; cfg_we_i = 0;
        look("R12 sync priority", int'(cur_seg_o), 1);
        // R4: zero count reloads at the first sector end
        reg_wr(3'd1, 0);
        reg_wr(3'd2, 50);
        sector(3, 0);
        look("R4 zero count reload seg", int'(cur_seg_o), 50);
        cmp("R4 zero count reload cnt", int'(cur_cnt_o), 15);
        step_idle(5);
        finish_run();
    end

endmodule